// File: doc/BRIEF.md
# Momentum Lookup Address Former

This block prepares the address for an external momentum table. It takes nine track candidates in parallel. For each candidate it has three per-station azimuth values, a polar coordinate, a track-type code and a flag that says whether a third segment exists. From these it builds one compact address per candidate. The work runs at the same time as the selection of the best three candidates, so the address only has to be routed out once the selection is known. The table itself sits outside the block.

Each candidate address holds two azimuth differences:

- **First difference:** station two minus station one, kept at full resolution over a narrow signed field.
- **Second difference:** station three minus station two. It is first made coarser by an arithmetic right shift, then kept over an even narrower field. It only has to separate scattering effects, so it needs less precision.

Both differences clamp at the signed limits of their field instead of wrapping. The polar bits and the type code are placed above the two differences. A two-segment track gets a zero second-difference field. The type code tells the table which layout applies.

When the three selection indices are marked valid, the chosen addresses appear on the output one clock later, together with a valid flag.

Top module: `momaddr_top`

## Requirements
- R1: Address bits [7:0] hold phi2 minus phi1 as an 8-bit two's-complement value whenever that difference lies within -128..127.
- R2: If phi2 minus phi1 is above 127, bits [7:0] read 0x7F. If it is below -128, they read 0x80.
- R3: Bits [12:8] hold floor((phi3 - phi2) / 4) as a 5-bit two's-complement value. It is clamped to 15 above and to -16 below.
- R4: A candidate whose third-segment flag is 0 has bits [12:8] equal to zero, whatever its phi3.
- R5: Bits [16:13] carry the upper four bits of the 6-bit polar input (eta[5:2]). Bits [19:17] carry the 3-bit track type.
- R6: Output slot k (bits [20k+19:20k]) shows the address of the candidate named by index slot k (bits [4k+3:4k]). It shows it one clock after `sel_valid_i` is high, with `addr_valid_o` high in that clock.
- R7: In the clock after `sel_valid_i` is low, `addr_valid_o` is low and every output address keeps its previous value, even if the candidate inputs change.
- R8: A selection index of 9 or more yields an all-zero address in its slot.
- R9: While reset is asserted (`rst_n` low), `addr_valid_o` is 0 and all output addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_valid_i | input | 1 | Selection indices are valid this clock |
| sel_idx_i | input | 12 | Three 4-bit candidate indices, slot 0 in the low bits |
| phi1_i | input | 108 | Station-one azimuth, 12 bits per candidate, candidate 0 in the low bits |
| phi2_i | input | 108 | Station-two azimuth, 12 bits per candidate |
| phi3_i | input | 108 | Station-three azimuth, 12 bits per candidate |
| has3_i | input | 9 | Third segment present, one bit per candidate |
| eta_i | input | 54 | Polar coordinate, 6 bits per candidate |
| type_i | input | 27 | Track-type code, 3 bits per candidate |
| addr_o | output | 60 | Three 20-bit lookup addresses, slot 0 in the low bits |
| addr_valid_o | output | 1 | Addresses were loaded from a valid selection |

## Verification
The main stimulus is a sweep. Each candidate gets its own first difference over -200..200 and its own second difference over -100..100, with the third-segment flag, polar value and type varied together. This pattern separates correct field packing and per-slot routing from swapped or shifted fields.

Directed cases target the exact limits 127/128 and -128/-129, and the full-range extremes. These expose wrap-around in place of clamping. Further cases cover negative odd second differences, which expose truncation toward zero in place of floor. Out-of-range indices and idle clocks with changing inputs tell apart a true hold from a register that keeps loading.

// File: rtl/momaddr_pkg.sv
package momaddr_pkg;
    localparam int MA_N_CAND   = 9;
    localparam int MA_N_SEL    = 3;
    localparam int MA_PHI_W    = 12;
    localparam int MA_D1_W     = 8;
    localparam int MA_D2_W     = 5;
    localparam int MA_D2_SHIFT = 2;
    localparam int MA_ETA_IN_W = 6;
    localparam int MA_ETA_W    = 4;
    localparam int MA_TYPE_W   = 3;
endpackage

// File: rtl/momaddr_diff_sat.sv
module momaddr_diff_sat #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 8,
    parameter int SHIFT = 0
) (
    input  logic [IN_W-1:0]  a_i,
    input  logic [IN_W-1:0]  b_i,
    output logic [OUT_W-1:0] y_o
);
    localparam logic signed [IN_W:0] MAX_S = {{(IN_W+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W:0] MIN_S = {{(IN_W+2-OUT_W){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0]     Y_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0]     Y_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [IN_W:0] diff;
    logic signed [IN_W:0] scaled;

    always_comb begin
        diff   = $signed({1'b0, b_i}) - $signed({1'b0, a_i});
        scaled = diff >>> SHIFT;
        if (scaled > MAX_S) begin
            y_o = Y_MAX;
        end else if (scaled < MIN_S) begin
            y_o = Y_MIN;
        end else begin
            y_o = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/momaddr_cand.sv
module momaddr_cand #(
    parameter int PHI_W    = 12,
    parameter int D1_W     = 8,
    parameter int D2_W     = 5,
    parameter int D2_SHIFT = 2,
    parameter int ETA_IN_W = 6,
    parameter int ETA_W    = 4,
    parameter int TYPE_W   = 3,
    localparam int ADDR_W  = TYPE_W + ETA_W + D2_W + D1_W
) (
    input  logic [PHI_W-1:0]    phi1_i,
    input  logic [PHI_W-1:0]    phi2_i,
    input  logic [PHI_W-1:0]    phi3_i,
    input  logic                has3_i,
    input  logic [ETA_IN_W-1:0] eta_i,
    input  logic [TYPE_W-1:0]   type_i,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [D1_W-1:0] d1;
    logic [D2_W-1:0] d2_raw;
    logic [D2_W-1:0] d2;

    momaddr_diff_sat #(.IN_W(PHI_W), .OUT_W(D1_W), .SHIFT(0)) u_d1 (
        .a_i(phi1_i), .b_i(phi2_i), .y_o(d1)
    );

    momaddr_diff_sat #(.IN_W(PHI_W), .OUT_W(D2_W), .SHIFT(D2_SHIFT)) u_d2 (
        .a_i(phi2_i), .b_i(phi3_i), .y_o(d2_raw)
    );

    always_comb begin
        d2     = has3_i ? d2_raw : '0;
        addr_o = {type_i, eta_i[ETA_IN_W-1 -: ETA_W], d2, d1};
    end
endmodule

// File: rtl/momaddr_pick.sv
module momaddr_pick #(
    parameter int N_CAND = 9,
    parameter int N_SEL  = 3,
    parameter int ADDR_W = 20,
    localparam int IDX_W = $clog2(N_CAND)
) (
    input  logic [N_CAND*ADDR_W-1:0] cand_addr_i,
    input  logic [N_SEL*IDX_W-1:0]   idx_i,
    output logic [N_SEL*ADDR_W-1:0]  addr_o
);
    for (genvar s = 0; s < N_SEL; s++) begin : g_slot
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] pick;
        always_comb begin
            idx  = idx_i[s*IDX_W +: IDX_W];
            pick = '0;
            for (int c = 0; c < N_CAND; c++) begin
                if (idx == IDX_W'(c)) begin
                    pick = cand_addr_i[c*ADDR_W +: ADDR_W];
                end
            end
        end
        assign addr_o[s*ADDR_W +: ADDR_W] = pick;
    end
endmodule

// File: rtl/momaddr_top.sv
module momaddr_top
    import momaddr_pkg::*;
#(
    parameter int N_CAND   = MA_N_CAND,
    parameter int N_SEL    = MA_N_SEL,
    parameter int PHI_W    = MA_PHI_W,
    parameter int D1_W     = MA_D1_W,
    parameter int D2_W     = MA_D2_W,
    parameter int D2_SHIFT = MA_D2_SHIFT,
    parameter int ETA_IN_W = MA_ETA_IN_W,
    parameter int ETA_W    = MA_ETA_W,
    parameter int TYPE_W   = MA_TYPE_W,
    localparam int ADDR_W  = TYPE_W + ETA_W + D2_W + D1_W,
    localparam int IDX_W   = $clog2(N_CAND)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_valid_i,
    input  logic [N_SEL*IDX_W-1:0]     sel_idx_i,
    input  logic [N_CAND*PHI_W-1:0]    phi1_i,
    input  logic [N_CAND*PHI_W-1:0]    phi2_i,
    input  logic [N_CAND*PHI_W-1:0]    phi3_i,
    input  logic [N_CAND-1:0]          has3_i,
    input  logic [N_CAND*ETA_IN_W-1:0] eta_i,
    input  logic [N_CAND*TYPE_W-1:0]   type_i,
    output logic [N_SEL*ADDR_W-1:0]    addr_o,
    output logic                       addr_valid_o
);
    typedef struct packed {
        logic                    valid;
        logic [N_SEL*ADDR_W-1:0] addr;
    } state_t;

    logic [N_CAND*ADDR_W-1:0] cand_addr;
    logic [N_SEL*ADDR_W-1:0]  sel_addr;
    state_t                   st_d, st_q;

    for (genvar c = 0; c < N_CAND; c++) begin : g_cand
        momaddr_cand #(
            .PHI_W(PHI_W), .D1_W(D1_W), .D2_W(D2_W), .D2_SHIFT(D2_SHIFT),
            .ETA_IN_W(ETA_IN_W), .ETA_W(ETA_W), .TYPE_W(TYPE_W)
        ) u_cand (
            .phi1_i (phi1_i[c*PHI_W +: PHI_W]),
            .phi2_i (phi2_i[c*PHI_W +: PHI_W]),
            .phi3_i (phi3_i[c*PHI_W +: PHI_W]),
            .has3_i (has3_i[c]),
            .eta_i  (eta_i[c*ETA_IN_W +: ETA_IN_W]),
            .type_i (type_i[c*TYPE_W +: TYPE_W]),
            .addr_o (cand_addr[c*ADDR_W +: ADDR_W])
        );
    end

    momaddr_pick #(.N_CAND(N_CAND), .N_SEL(N_SEL), .ADDR_W(ADDR_W)) u_pick (
        .cand_addr_i (cand_addr),
        .idx_i       (sel_idx_i),
        .addr_o      (sel_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = sel_valid_i;
        if (sel_valid_i) begin
            st_d.addr = sel_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o       = st_q.addr;
    assign addr_valid_o = st_q.valid;
endmodule

// File: rtl/momaddr_chk.sv
module momaddr_chk #(
    parameter int N_CAND = 9,
    parameter int N_SEL  = 3,
    parameter int PHI_W  = 12,
    parameter int D1_W   = 8,
    parameter int D2_W   = 5,
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_valid_i,
    input logic [N_SEL*IDX_W-1:0]  sel_idx_i,
    input logic [N_CAND*PHI_W-1:0] phi1_i,
    input logic [N_CAND*PHI_W-1:0] phi2_i,
    input logic [N_CAND-1:0]       has3_i,
    input logic [N_SEL*ADDR_W-1:0] addr_o,
    input logic                    addr_valid_o
);
    localparam int D1_MAX = (1 << (D1_W - 1)) - 1;
    localparam int D1_MIN = -(1 << (D1_W - 1));

    logic [IDX_W-1:0] idx0;
    logic             in_rng;
    int               k;
    int               d1;
    logic             no3;

    always_comb begin
        idx0   = sel_idx_i[IDX_W-1:0];
        in_rng = int'(idx0) < N_CAND;
        k      = in_rng ? int'(idx0) : 0;
        d1     = int'(phi2_i[k*PHI_W +: PHI_W]) - int'(phi1_i[k*PHI_W +: PHI_W]);
        no3    = !has3_i[k];
    end

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_i |=> addr_valid_o);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_i |=> (!addr_valid_o && $stable(addr_o)));

    p_zero_oor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && !in_rng) |=> (addr_o[ADDR_W-1:0] == '0));

    p_sat_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && in_rng && d1 > D1_MAX) |=> (addr_o[D1_W-1:0] == {1'b0, {(D1_W-1){1'b1}}}));

    p_sat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && in_rng && d1 < D1_MIN) |=> (addr_o[D1_W-1:0] == {1'b1, {(D1_W-1){1'b0}}}));

    p_two_seg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_i && in_rng && no3) |=> (addr_o[D1_W +: D2_W] == '0));
endmodule

bind momaddr_top momaddr_chk #(
    .N_CAND(N_CAND), .N_SEL(N_SEL), .PHI_W(PHI_W), .D1_W(D1_W),
    .D2_W(D2_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_valid_i(sel_valid_i), .sel_idx_i(sel_idx_i),
    .phi1_i(phi1_i), .phi2_i(phi2_i), .has3_i(has3_i),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o)
);

// File: tb/momaddr_top_tb_top.sv
`timescale 1ns/1ps
module momaddr_top_tb_top;
    localparam int NC = 9;
    localparam int NS = 3;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_valid_i = 1'b0;
    logic [11:0]   sel_idx_i = '0;
    logic [107:0]  phi1_i = '0, phi2_i = '0, phi3_i = '0;
    logic [8:0]    has3_i = '0;
    logic [53:0]   eta_i = '0;
    logic [26:0]   type_i = '0;
    logic [59:0]   addr_o;
    logic          addr_valid_o;

    int bp1 [NC], bp2 [NC], bp3 [NC], beta [NC], bty [NC];
    bit bh3 [NC];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    momaddr_top dut_i (
        .clk(clk), .rst_n(rst_n), .sel_valid_i(sel_valid_i), .sel_idx_i(sel_idx_i),
        .phi1_i(phi1_i), .phi2_i(phi2_i), .phi3_i(phi3_i), .has3_i(has3_i),
        .eta_i(eta_i), .type_i(type_i), .addr_o(addr_o), .addr_valid_o(addr_valid_o)
    );

    function automatic int clamp(int v, int lo, int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic logic [AW-1:0] model(int c);
        int d1 = clamp(bp2[c] - bp1[c], -128, 127);
        int d2 = bh3[c] ? clamp((bp3[c] - bp2[c]) >>> 2, -16, 15) : 0;
        logic [7:0] f1 = 8'(d1);
        logic [4:0] f2 = 5'(d2);
        logic [5:0] e  = 6'(beta[c]);
        return {3'(bty[c]), e[5:2], f2, f1};
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    task automatic drive();
        for (int c = 0; c < NC; c++) begin
            phi1_i[c*12 +: 12] = 12'(bp1[c]);
            phi2_i[c*12 +: 12] = 12'(bp2[c]);
            phi3_i[c*12 +: 12] = 12'(bp3[c]);
            has3_i[c]          = bh3[c];
            eta_i[c*6 +: 6]    = 6'(beta[c]);
            type_i[c*3 +: 3]   = 3'(bty[c]);
        end
    endtask

    // drive at negedge, register at posedge, sample at next negedge
    task automatic sel3(int i0, int i1, int i2, string req);
        int ix [NS];
        ix[0] = i0; ix[1] = i1; ix[2] = i2;
        drive();
        sel_idx_i   = {4'(i2), 4'(i1), 4'(i0)};
        sel_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sel_valid_i = 1'b0;
        chk({req, " R6 valid"}, AW'(addr_valid_o), AW'(1));
        for (int s = 0; s < NS; s++) begin
            chk(req, addr_o[s*AW +: AW], (ix[s] < NC) ? model(ix[s]) : '0);
        end
    endtask

    task automatic set_cand(int c, int p1, int p2, int p3, bit h3, int e, int t);
        bp1[c] = p1; bp2[c] = p2; bp3[c] = p3; bh3[c] = h3; beta[c] = e; bty[c] = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [59:0] held;
        for (int c = 0; c < NC; c++) set_cand(c, 0, 0, 0, 1'b0, 0, 0);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 valid", AW'(addr_valid_o), '0);
        for (int s = 0; s < NS; s++) chk("R9 addr", addr_o[s*AW +: AW], '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R5 R6: sweep of differences, flags, polar and type
        for (int step = 0; step < 400; step++) begin
            for (int c = 0; c < NC; c++) begin
                int p1 = 1000 + (step * 13 + c * 97) % 2000;
                int p2 = p1 - 200 + (step * 7 + c * 53) % 401;
                int p3 = p2 - 100 + (step * 11 + c * 29) % 201;
                set_cand(c, p1, p2, p3, ((step + c) % 3) != 0,
                         (step * 5 + c) % 64, (step + c) % 8);
            end
            sel3(step % NC, (step + 4) % NC, (step + 7) % NC, "R1 R3 R4 R5 R6 sweep");
        end

        // R2: exact limits and extremes of the first difference
        set_cand(0, 100, 227, 227, 1'b1, 63, 7);    // +127 kept
        set_cand(1, 100, 228, 228, 1'b1, 0, 1);     // +128 clamps
        set_cand(2, 300, 172, 172, 1'b1, 12, 2);    // -128 kept
        set_cand(3, 300, 171, 171, 1'b1, 33, 3);    // -129 clamps
        set_cand(4, 0, 4095, 4095, 1'b1, 5, 4);     // max positive
        set_cand(5, 4095, 0, 0, 1'b1, 40, 5);       // max negative
        sel3(0, 1, 2, "R1 R2 limits");
        sel3(3, 4, 5, "R2 extremes");
        // R2 field values stated directly
        chk("R2 high clamp", AW'(addr_o[20 +: 8]), AW'(8'h7F));
        chk("R2 low clamp", AW'(addr_o[0 +: 8]), AW'(8'h80));

        // R3: floor on negative odd, clamp on second difference; R4 ignores phi3
        set_cand(0, 500, 500, 497, 1'b1, 8, 0);     // -3 -> -1
        set_cand(1, 500, 500, 560, 1'b1, 8, 0);     // 60 -> 15
        set_cand(2, 500, 500, 564, 1'b1, 8, 0);     // 64 -> 16 clamps 15
        set_cand(3, 500, 500, 436, 1'b1, 8, 0);     // -64 -> -16
        set_cand(4, 500, 500, 435, 1'b1, 8, 0);     // -65 -> -17 clamps
        set_cand(5, 500, 500, 4095, 1'b0, 8, 0);    // two segments
        sel3(0, 1, 2, "R3 floor/clamp");
        chk("R3 floor -3", AW'(addr_o[8 +: 5]), AW'(5'h1F));
        sel3(3, 4, 5, "R3 R4 clamp/two-seg");
        chk("R4 zero field", AW'(addr_o[48 +: 5]), '0);

        // R8: out-of-range indices
        sel3(9, 15, 2, "R8 oor");
        sel3(0, 12, 10, "R8 oor");

        // R7: idle clocks hold the outputs while inputs change
        sel3(6, 7, 8, "R6 last slots");
        held = addr_o;
        for (int c = 0; c < NC; c++) set_cand(c, 7, 3000, 9, 1'b1, 63, 7);
        drive();
        sel_idx_i = 12'h321;
        repeat (3) begin
            @(negedge clk);
            chk("R7 valid low", AW'(addr_valid_o), '0);
            for (int s = 0; s < NS; s++) chk("R7 hold", addr_o[s*AW +: AW], held[s*AW +: AW]);
        end

        // R9: reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 valid again", AW'(addr_valid_o), '0);
        for (int s = 0; s < NS; s++) chk("R9 addr again", addr_o[s*AW +: AW], '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule